// File: doc/BRIEF.md
# Prioritized Memory Access Permission Checker

This block decides whether a single memory access may proceed. A request carries a byte address, a size, the requested read/write/execute set and a 2-bit privilege mode. The block tests the first and the last byte of the access against a bank of already-decoded protection regions. Each region is described by an inclusive lower bound, an inclusive upper bound and a configuration byte. The region with the lowest index that decides the access supplies the permissions. If no region decides, a default policy applies. That policy is steered by two security bits: a lockdown bit and a deny-by-default bit.

Requests enter through a valid/ready port and verdicts leave through a valid/ready port. The stage holds one verdict. A new request is accepted when the output slot is empty, or when the verdict in it is taken in the same cycle (`req_ready = !rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the verdict stays frozen and no request is taken. Region bounds, configuration bytes, the active-region count and the security bits are plain level inputs. They are sampled in the cycle a request is accepted.

Top module: `pmc_checker`

## Requirements
- R1: Each configuration byte is laid out as follows: bit 0 R, bit 1 W, bit 2 X, bits 4:3 match mode (00 = region disabled), bit 7 lock. Regions are scanned from index 0 upward, and the first region that decides the access determines the verdict. A higher-indexed region is never consulted after a lower one has decided.
- R2: The last byte of the access is address + size − 1, and a size of 0 stands for one 4-byte word (XLEN/8). If exactly one of the first and last byte lies inside a region's inclusive bounds, that region decides and the access is denied with an empty allowed set.
- R3: When the active-region count is zero, the default policy applies and the regions are not examined at all, not even for straddling. The default policy also applies when no region decides.
- R4: Default policy (mode 2'b11 is machine mode). If the deny-by-default bit is set, the result is allowed = none, not granted. Otherwise, if lockdown is set, machine mode is granted with allowed = RW as long as X is not requested; any other case is allowed = none, not granted. Otherwise, machine mode is granted with allowed = RWX, and other modes get allowed = none, not granted.
- R5: When lockdown is clear and a region matches fully, machine mode gets RWX unless the region's lock bit is set. In every other case the allowed set equals the region's R/W/X bits.
- R6: When lockdown is set and a region matches fully in machine mode, the allowed set is looked up by the index {L,R,W,X}. Indices 2, 3 and 14 give RW. Indices 9 and 10 give X. Indices 11 and 13 give RX. Indices 12 and 15 give R. All other indices give none.
- R7: When lockdown is set and a region matches fully in any other mode, the allowed set is looked up by the index {L,R,W,X}. Indices 1, 10 and 11 give X. Indices 2, 4 and 15 give R. Indices 3 and 6 give RW. Index 5 gives RX. Index 7 gives RWX. All other indices give none.
- R8: For a full match, the access is granted exactly when every requested permission is in the allowed set. An empty request is therefore granted. rsp_allow encodes the set as bit 0 R, bit 1 W, bit 2 X.
- R9: After reset, rsp_valid is 0 and req_ready is 1. A request accepted at a clock edge appears on rsp_valid/rsp_allow/rsp_grant right after that edge. While rsp_valid is high and rsp_ready is low, req_ready is 0 and the verdict stays unchanged.
- R10: A region whose match mode is 00 never matches fully, so a later region may decide instead. Its bounds still take part in the straddle test of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | 32 | Byte address of the first byte |
| req_size | input | 4 | Access size in bytes, 0 = one word |
| req_perm | input | 3 | Requested set: bit 0 R, bit 1 W, bit 2 X |
| req_mode | input | 2 | Privilege mode, 2'b11 = machine |
| ent_lo | input | 256 | Packed inclusive lower bounds, region i at [i*32 +: 32] |
| ent_hi | input | 256 | Packed inclusive upper bounds, region i at [i*32 +: 32] |
| ent_cfg | input | 64 | Packed configuration bytes, region i at [i*8 +: 8] |
| active_rules | input | 4 | Number of enabled regions; zero forces the default policy |
| sec_lockdown | input | 1 | Machine-mode lockdown |
| sec_deny_default | input | 1 | Deny everything that no region decides |
| rsp_valid | output | 1 | Verdict present |
| rsp_ready | input | 1 | Consumer takes the verdict |
| rsp_allow | output | 3 | Allowed set: bit 0 R, bit 1 W, bit 2 X |
| rsp_grant | output | 1 | Access granted |

## Verification
The embedded properties assume that the region bounds, configuration bytes, active count and security bits do not change while a request is being accepted. They also assume that the consumer never needs the verdict to change while it holds rsp_ready low. The bench meets both assumptions: it changes the configuration only at falling edges, between handshakes, and it drops rsp_ready only inside the dedicated back-pressure sequence. Random regions are placed in a narrow low address window and random accesses are drawn near it, so that full matches, straddles and misses all occur often. Unused regions are parked far above that window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam logic [1:0] MODE_MACHINE = 2'b11;

  localparam int CFG_R    = 0;
  localparam int CFG_W    = 1;
  localparam int CFG_X    = 2;
  localparam int CFG_A_LO = 3;
  localparam int CFG_L    = 7;

  localparam logic [2:0] PERM_NONE = 3'b000;
  localparam logic [2:0] PERM_R    = 3'b001;
  localparam logic [2:0] PERM_X    = 3'b100;
  localparam logic [2:0] PERM_RW   = 3'b011;
  localparam logic [2:0] PERM_RX   = 3'b101;
  localparam logic [2:0] PERM_RWX  = 3'b111;

  typedef struct packed {
    logic [2:0] allow;
    logic       grant;
  } verdict_t;

  // Lockdown table index: {lock, read, write, execute}
  function automatic logic [3:0] lock_index(input logic [7:0] cfg);
    return {cfg[CFG_L], cfg[CFG_R], cfg[CFG_W], cfg[CFG_X]};
  endfunction

  function automatic logic [2:0] lock_perm_machine(input logic [3:0] k);
    logic [2:0] p;
    case (k)
      4'd2, 4'd3, 4'd14: p = PERM_RW;
      4'd9, 4'd10:       p = PERM_X;
      4'd11, 4'd13:      p = PERM_RX;
      4'd12, 4'd15:      p = PERM_R;
      default:           p = PERM_NONE;
    endcase
    return p;
  endfunction

  function automatic logic [2:0] lock_perm_other(input logic [3:0] k);
    logic [2:0] p;
    case (k)
      4'd1, 4'd10, 4'd11: p = PERM_X;
      4'd2, 4'd4, 4'd15:  p = PERM_R;
      4'd3, 4'd6:         p = PERM_RW;
      4'd5:               p = PERM_RX;
      4'd7:               p = PERM_RWX;
      default:            p = PERM_NONE;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/pmc_range_test.sv
module pmc_range_test #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] lo,
  input  logic [XLEN-1:0] hi,
  input  logic [XLEN-1:0] first_b,
  input  logic [XLEN-1:0] last_b,
  input  logic            mode_on,
  output logic            full_hit,
  output logic            part_hit
);
  logic first_in, last_in;

  always_comb begin
    first_in = (first_b >= lo) && (first_b <= hi);
    last_in  = (last_b  >= lo) && (last_b  <= hi);
    part_hit = first_in ^ last_in;
    full_hit = first_in && last_in && mode_on;
  end
endmodule

// File: rtl/pmc_entry_bank.sv
module pmc_entry_bank #(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32
) (
  input  logic [XLEN-1:0]             first_b,
  input  logic [XLEN-1:0]             last_b,
  input  logic [NUM_ENTRIES*XLEN-1:0] ent_lo,
  input  logic [NUM_ENTRIES*XLEN-1:0] ent_hi,
  input  logic [NUM_ENTRIES-1:0]      mode_on,
  output logic [NUM_ENTRIES-1:0]      full_vec,
  output logic [NUM_ENTRIES-1:0]      part_vec
);
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    pmc_range_test #(.XLEN(XLEN)) u_rt (
      .lo       (ent_lo[g*XLEN +: XLEN]),
      .hi       (ent_hi[g*XLEN +: XLEN]),
      .first_b  (first_b),
      .last_b   (last_b),
      .mode_on  (mode_on[g]),
      .full_hit (full_vec[g]),
      .part_hit (part_vec[g])
    );
  end
endmodule

// File: rtl/pmc_prio_select.sv
module pmc_prio_select #(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_ENTRIES-1:0]   full_vec,
  input  logic [NUM_ENTRIES-1:0]   part_vec,
  input  logic [NUM_ENTRIES*8-1:0] ent_cfg,
  output logic                     found,
  output logic                     is_partial,
  output logic [7:0]               sel_cfg
);
  localparam logic [NUM_ENTRIES-1:0] ONE = NUM_ENTRIES'(1);

  logic [NUM_ENTRIES-1:0] cand, hit;

  always_comb begin
    cand       = full_vec | part_vec;
    hit        = cand & (~cand + ONE);
    found      = |cand;
    is_partial = |(hit & part_vec);
    sel_cfg    = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit[i]) sel_cfg = sel_cfg | ent_cfg[i*8 +: 8];
    end
  end

  // R1: at most one region decides
  a_r1_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit));
  // R1: the deciding region has no candidate below it
  a_r1_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> ((cand & (hit - ONE)) == '0) && (hit != '0));
endmodule

// File: rtl/pmc_perm_eval.sv
module pmc_perm_eval
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rules_active,
  input  logic       found,
  input  logic       is_partial,
  input  logic [7:0] sel_cfg,
  input  logic [2:0] req_perm,
  input  logic [1:0] req_mode,
  input  logic       sec_lockdown,
  input  logic       sec_deny_default,
  output verdict_t   verdict
);
  logic       is_machine, use_default;
  logic [2:0] match_allow;
  logic       unused_cfg_bits;

  assign unused_cfg_bits = ^sel_cfg[6:3];

  always_comb begin
    is_machine  = (req_mode == MODE_MACHINE);
    use_default = !rules_active || !found;

    if (!sec_lockdown) begin
      if (is_machine && !sel_cfg[CFG_L]) match_allow = PERM_RWX;
      else                               match_allow = sel_cfg[2:0];
    end else if (is_machine) begin
      match_allow = lock_perm_machine(lock_index(sel_cfg));
    end else begin
      match_allow = lock_perm_other(lock_index(sel_cfg));
    end

    if (use_default) begin
      if (sec_deny_default) begin
        verdict = '{allow: PERM_NONE, grant: 1'b0};
      end else if (sec_lockdown) begin
        if (is_machine && !req_perm[CFG_X]) verdict = '{allow: PERM_RW, grant: 1'b1};
        else                                verdict = '{allow: PERM_NONE, grant: 1'b0};
      end else if (is_machine) begin
        verdict = '{allow: PERM_RWX, grant: 1'b1};
      end else begin
        verdict = '{allow: PERM_NONE, grant: 1'b0};
      end
    end else if (is_partial) begin
      verdict = '{allow: PERM_NONE, grant: 1'b0};
    end else begin
      verdict.allow = match_allow;
      verdict.grant = ((req_perm & ~match_allow) == 3'b000);
    end
  end

  // R4: deny-by-default empties the allowed set when nothing decides
  a_r4_deny_default: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_deny_default && (!rules_active || !found)) |-> (verdict.allow == PERM_NONE) && !verdict.grant);
  // R2: a straddling access is never granted
  a_r2_straddle_denied: assert property (@(posedge clk) disable iff (!rst_n)
    (rules_active && found && is_partial) |-> !verdict.grant);
  // R8: a grant never exceeds the allowed set
  a_r8_grant_subset: assert property (@(posedge clk) disable iff (!rst_n)
    verdict.grant |-> ((req_perm & ~verdict.allow) == 3'b000));
  // R6: lockdown never lets machine mode both write and execute a matched region
  a_r6_no_wx_machine: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_lockdown && is_machine && rules_active && found && !is_partial)
      |-> !(verdict.allow[1] && verdict.allow[2]));
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
  import pmc_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int XLEN        = 32,
  parameter int SIZE_W      = 4,
  localparam int CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [XLEN-1:0]          req_addr,
  input  logic [SIZE_W-1:0]        req_size,
  input  logic [2:0]               req_perm,
  input  logic [1:0]               req_mode,
  input  logic [NUM_ENTRIES*XLEN-1:0] ent_lo,
  input  logic [NUM_ENTRIES*XLEN-1:0] ent_hi,
  input  logic [NUM_ENTRIES*8-1:0] ent_cfg,
  input  logic [CNT_W-1:0]         active_rules,
  input  logic                     sec_lockdown,
  input  logic                     sec_deny_default,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [2:0]               rsp_allow,
  output logic                     rsp_grant
);
  localparam int WORD_BYTES = XLEN / 8;

  logic [XLEN-1:0]        eff_size, last_b;
  logic [NUM_ENTRIES-1:0] mode_on, full_vec, part_vec;
  logic                   found, is_partial, accept;
  logic [7:0]             sel_cfg;
  verdict_t               verdict_c;

  always_comb begin
    eff_size = (req_size == '0) ? XLEN'(WORD_BYTES) : XLEN'(req_size);
    last_b   = req_addr + eff_size - XLEN'(1);
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_mode
    assign mode_on[g] = |ent_cfg[g*8 + CFG_A_LO +: 2];
  end

  pmc_entry_bank #(.NUM_ENTRIES(NUM_ENTRIES), .XLEN(XLEN)) u_bank (
    .first_b  (req_addr),
    .last_b   (last_b),
    .ent_lo   (ent_lo),
    .ent_hi   (ent_hi),
    .mode_on  (mode_on),
    .full_vec (full_vec),
    .part_vec (part_vec)
  );

  pmc_prio_select #(.NUM_ENTRIES(NUM_ENTRIES)) u_prio (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_vec   (full_vec),
    .part_vec   (part_vec),
    .ent_cfg    (ent_cfg),
    .found      (found),
    .is_partial (is_partial),
    .sel_cfg    (sel_cfg)
  );

  pmc_perm_eval u_eval (
    .clk              (clk),
    .rst_n            (rst_n),
    .rules_active     (active_rules != '0),
    .found            (found),
    .is_partial       (is_partial),
    .sel_cfg          (sel_cfg),
    .req_perm         (req_perm),
    .req_mode         (req_mode),
    .sec_lockdown     (sec_lockdown),
    .sec_deny_default (sec_deny_default),
    .verdict          (verdict_c)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_allow <= 3'b000;
      rsp_grant <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_allow <= verdict_c.allow;
      rsp_grant <= verdict_c.grant;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R9: a stalled verdict is held
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_allow) && $stable(rsp_grant));
  // R9: every accepted request produces a verdict on the next cycle
  a_r9_accept_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);
endmodule

// File: tb/tb_pmc_checker.sv
`timescale 1ns/1ps
module tb_pmc_checker;
  localparam int NE = 8;
  localparam int XL = 32;
  localparam int SW = 4;
  localparam int CW = $clog2(NE + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic           rst_n, req_valid, req_ready, rsp_valid, rsp_ready, rsp_grant;
  logic [XL-1:0]  req_addr;
  logic [SW-1:0]  req_size;
  logic [2:0]     req_perm, rsp_allow;
  logic [1:0]     req_mode;
  logic [NE*XL-1:0] ent_lo, ent_hi;
  logic [NE*8-1:0]  ent_cfg;
  logic [CW-1:0]  active_rules;
  logic           sec_lockdown, sec_deny_default;

  logic [XL-1:0]  b_lo [NE];
  logic [XL-1:0]  b_hi [NE];
  logic [7:0]     b_cfg [NE];

  always_comb begin
    for (int i = 0; i < NE; i++) begin
      ent_lo[i*XL +: XL] = b_lo[i];
      ent_hi[i*XL +: XL] = b_hi[i];
      ent_cfg[i*8 +: 8]  = b_cfg[i];
    end
  end

  pmc_checker #(.NUM_ENTRIES(NE), .XLEN(XL), .SIZE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size), .req_perm(req_perm), .req_mode(req_mode),
    .ent_lo(ent_lo), .ent_hi(ent_hi), .ent_cfg(ent_cfg), .active_rules(active_rules),
    .sec_lockdown(sec_lockdown), .sec_deny_default(sec_deny_default),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_allow(rsp_allow), .rsp_grant(rsp_grant)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  function automatic logic [2:0] tb_tab_m(input logic [3:0] k);
    case (k)
      2, 3, 14: return 3'b011;
      9, 10:    return 3'b100;
      11, 13:   return 3'b101;
      12, 15:   return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] tb_tab_o(input logic [3:0] k);
    case (k)
      1, 10, 11: return 3'b100;
      2, 4, 15:  return 3'b001;
      3, 6:      return 3'b011;
      5:         return 3'b101;
      7:         return 3'b111;
      default:   return 3'b000;
    endcase
  endfunction

  // returns {grant, allow}
  function automatic logic [3:0] model(input logic [XL-1:0] a, input logic [SW-1:0] sz,
                                       input logic [2:0] rq, input logic [1:0] md);
    logic [XL-1:0] last;
    int   win;
    bit   part;
    logic [2:0] al;
    logic g;
    logic [7:0] c;
    win  = -1;
    part = 1'b0;
    last = a + ((sz == 0) ? XL'(XL/8) : XL'(sz)) - XL'(1);
    if (active_rules != 0) begin
      for (int i = 0; i < NE; i++) begin
        bit s, e;
        s = (a >= b_lo[i]) && (a <= b_hi[i]);
        e = (last >= b_lo[i]) && (last <= b_hi[i]);
        if (win < 0) begin
          if (s != e) begin win = i; part = 1'b1; end
          else if (s && e && b_cfg[i][4:3] != 2'b00) win = i;
        end
      end
    end
    if (win < 0) begin
      if (sec_deny_default) begin al = 0; g = 0; end
      else if (sec_lockdown) begin
        if (md == 2'b11 && !rq[2]) begin al = 3'b011; g = 1; end
        else begin al = 0; g = 0; end
      end else if (md == 2'b11) begin al = 3'b111; g = 1; end
      else begin al = 0; g = 0; end
    end else if (part) begin
      al = 0; g = 0;
    end else begin
      c = b_cfg[win];
      if (!sec_lockdown) al = (md != 2'b11 || c[7]) ? c[2:0] : 3'b111;
      else if (md == 2'b11) al = tb_tab_m({c[7], c[0], c[1], c[2]});
      else al = tb_tab_o({c[7], c[0], c[1], c[2]});
      g = ((rq & ~al) == 3'b000);
    end
    return {g, al};
  endfunction

  task automatic check_rsp(input logic [3:0] exp, input string tag);
    checks++;
    if (!rsp_valid || rsp_grant !== exp[3] || rsp_allow !== exp[2:0]) begin
      errors++;
      $display("FAIL %s: valid=%b allow=%b grant=%b expected valid=1 allow=%b grant=%b",
               tag, rsp_valid, rsp_allow, rsp_grant, exp[2:0], exp[3]);
    end
  endtask

  task automatic send(input logic [XL-1:0] a, input logic [SW-1:0] sz, input logic [2:0] rq,
                      input logic [1:0] md, input string tag);
    logic [3:0] exp;
    @(negedge clk);
    req_addr = a; req_size = sz; req_perm = rq; req_mode = md; req_valid = 1'b1;
    exp = model(a, sz, rq, md);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(exp, tag);
  endtask

  task automatic send_exp(input logic [XL-1:0] a, input logic [SW-1:0] sz, input logic [2:0] rq,
                          input logic [1:0] md, input logic [3:0] exp, input string tag);
    @(negedge clk);
    req_addr = a; req_size = sz; req_perm = rq; req_mode = md; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(exp, tag);
  endtask

  task automatic park_all();
    for (int i = 0; i < NE; i++) begin
      b_lo[i]  = 32'h8000_0000 + 32'(i) * 32'h1000;
      b_hi[i]  = b_lo[i] + 32'h0FFF;
      b_cfg[i] = 8'h00;
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] exp_a, exp_b;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    req_addr = '0; req_size = '0; req_perm = '0; req_mode = '0;
    active_rules = '0; sec_lockdown = 1'b0; sec_deny_default = 1'b0;
    park_all();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    checks++;
    if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
      errors++;
      $display("FAIL R9 reset: rsp_valid=%b req_ready=%b expected 0 1", rsp_valid, req_ready);
    end

    // R1 priority: region 0 R only, region 1 RWX
    b_lo[0] = 32'h100; b_hi[0] = 32'h1FF; b_cfg[0] = 8'h09;
    b_lo[1] = 32'h100; b_hi[1] = 32'h2FF; b_cfg[1] = 8'h0F;
    active_rules = 2;
    send_exp(32'h140, 4, 3'b001, 2'b00, 4'b1_001, "R1 low index wins read");
    send_exp(32'h140, 4, 3'b010, 2'b00, 4'b0_001, "R1 low index wins write denied");
    send_exp(32'h240, 4, 3'b010, 2'b00, 4'b1_111, "R1 falls to region 1");

    // R2 straddle, size zero
    send_exp(32'h1FE, 4, 3'b000, 2'b00, 4'b0_000, "R2 straddle denies");
    send_exp(32'h1FC, 0, 3'b001, 2'b00, 4'b1_001, "R2 size zero fits");
    send_exp(32'h1FD, 0, 3'b001, 2'b00, 4'b0_000, "R2 size zero straddles");

    // R10 disabled region
    b_cfg[0] = 8'h01;
    send_exp(32'h140, 4, 3'b100, 2'b00, 4'b1_111, "R10 disabled region skipped");
    send_exp(32'h1FE, 4, 3'b001, 2'b00, 4'b0_000, "R10 disabled region straddle");

    // R3 no active rules
    active_rules = 0;
    send_exp(32'h1FE, 4, 3'b111, 2'b11, 4'b1_111, "R3 zero count machine");
    send_exp(32'h1FE, 4, 3'b000, 2'b00, 4'b0_000, "R3 zero count user");
    active_rules = 2;
    send_exp(32'h500, 4, 3'b000, 2'b00, 4'b0_000, "R3 no match user");
    send_exp(32'h500, 4, 3'b101, 2'b11, 4'b1_111, "R3 no match machine");

    // R4 default policy variants
    sec_deny_default = 1'b1;
    send_exp(32'h500, 4, 3'b000, 2'b11, 4'b0_000, "R4 deny default");
    sec_deny_default = 1'b0; sec_lockdown = 1'b1;
    send_exp(32'h500, 4, 3'b001, 2'b11, 4'b1_011, "R4 lockdown machine read");
    send_exp(32'h500, 4, 3'b100, 2'b11, 4'b0_000, "R4 lockdown machine exec");
    send_exp(32'h500, 4, 3'b001, 2'b01, 4'b0_000, "R4 lockdown user");
    sec_lockdown = 1'b0;

    // R5 lock bit in machine mode
    b_cfg[1] = 8'h89;
    send_exp(32'h240, 4, 3'b010, 2'b11, 4'b0_001, "R5 locked region binds machine");
    b_cfg[1] = 8'h09;
    send_exp(32'h240, 4, 3'b010, 2'b11, 4'b1_111, "R5 unlocked region machine RWX");

    // R6 / R7 full lockdown tables
    sec_lockdown = 1'b1;
    b_lo[1] = 32'h8000_1000; b_hi[1] = 32'h8000_1FFF; b_cfg[1] = 8'h00;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      b_cfg[0] = {kk[3], 4'b0001, kk[0], kk[1], kk[2]};
      send_exp(32'h140, 4, 3'b000, 2'b11, {1'b1, tb_tab_m(kk)}, "R6 machine table");
      send_exp(32'h140, 4, 3'b000, 2'b00, {1'b1, tb_tab_o(kk)}, "R7 other table");
    end
    sec_lockdown = 1'b0;

    // R9 back-pressure
    b_cfg[0] = 8'h09;
    @(negedge clk);
    rsp_ready = 1'b0;
    req_addr = 32'h140; req_size = 4; req_perm = 3'b001; req_mode = 2'b00; req_valid = 1'b1;
    exp_a = model(req_addr, req_size, req_perm, req_mode);
    @(negedge clk);
    check_rsp(exp_a, "R9 first verdict");
    req_addr = 32'h140; req_perm = 3'b010;
    exp_b = model(req_addr, req_size, req_perm, req_mode);
    checks++;
    if (req_ready !== 1'b0) begin
      errors++;
      $display("FAIL R9 stall: req_ready=%b expected 0", req_ready);
    end
    @(negedge clk);
    check_rsp(exp_a, "R9 verdict held");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(exp_b, "R9 second verdict");

    // R8 random mix
    for (int n = 0; n < 4000; n++) begin
      park_all();
      for (int i = 0; i < NE; i++) begin
        if ($urandom_range(0, 3) != 0) begin
          b_lo[i]  = 32'($urandom_range(0, 32'h3FF));
          b_hi[i]  = b_lo[i] + 32'($urandom_range(0, 32'h7F));
          b_cfg[i] = 8'($urandom_range(0, 255));
        end
      end
      active_rules     = ($urandom_range(0, 7) == 0) ? '0 : CW'($urandom_range(1, NE));
      sec_lockdown     = 1'($urandom_range(0, 1));
      sec_deny_default = ($urandom_range(0, 5) == 0);
      send(32'($urandom_range(0, 32'h47F)), SW'($urandom_range(0, 15)),
           3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), "R8 random");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule